// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a position count. It counts every edge of either phase, so one full cycle of the phases moves the count by four. The phase order gives the direction. An index input can zero the count. An index pulse is accepted only while the two phases sit at a chosen level pair, and only on a chosen edge of that gated pulse. A ceiling register bounds the count in both directions: counting up past the ceiling gives zero, and counting down from zero gives the ceiling.

Four events are latched in an interrupt status register: wrap up, wrap down, direction change, and a watchdog that fires when the phases stay idle for a programmed number of cycles. Writing a one to a status bit clears it. A mask register selects which latched events drive the interrupt line. Software reaches the block through a plain word-addressed register port with a single-cycle write strobe and a combinational read. The encoder inputs must already be synchronised to `clk`.

Top module: `quad_pos_counter`

## Requirements
- R1: Each single-phase change of the (possibly swapped) A/B pair moves the count by one. The forward order A,B = 00→10→11→01→00 counts up and the reverse order counts down. The count changes on the first clock edge that samples the new phase levels.
- R2: Control bit 5 set swaps A and B before decoding, so the forward order counts down.
- R3: With control bit 0 clear, the count holds and no status bit is set by phase or index activity.
- R4: An up step while count ≥ ceiling sets the count to zero and sets status bit 2.
- R5: A down step at count zero loads the ceiling and sets status bit 1.
- R6: With control bit 8 clear, an accepted index edge forces the count to zero. The index is accepted only while (A,B) equals control bits 10:9 as {A,B} (0: low/low, 1: low/high, 2: high/low, 3: high/high), on the rising edge of the gated pulse when control bit 4 is set and on the falling edge when it is clear. With bit 8 set, the index has no effect on the count. If an accepted index and a step fall in the same cycle, the index wins.
- R7: A counted step whose direction differs from the previous counted step sets status bit 3. The direction after reset is up.
- R8: The watchdog timeout register (address 3) resets to 0x1000. Status bit 0 is set once exactly that many enabled clock edges after the last sampled A/B change. A value of zero disables the watchdog.
- R9: Writing ones to the status register (address 4) clears those bits, and an event in the same cycle wins. `irq` is high while any status bit is set whose mask bit (address 5) is clear. Status bits 5:4 always read zero.
- R10: A sample in which A and B both change leaves the count unchanged and sets the sticky control bit 7. Writing the control register with bit 7 set clears it.
- R11: Register map: 0 control, 1 ceiling, 2 count (read-only), 3 watchdog timeout, 4 status, 5 mask. Control bits 2, 3 and 4 are edge selects for A, B and index. After reset, control reads 0x11C, ceiling is all ones, and count, status and mask read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder phase A, synchronised |
| encB | input | 1 | Encoder phase B, synchronised |
| encIdx | input | 1 | Encoder index, synchronised |
| regAddr | input | 3 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with a 12-bit count, so the reset ceiling is 0xFFF. With that width, a single down step from zero shows the full-range wrap. The watchdog counter keeps its 16-bit default, and the bench programs a short timeout of 20 so the exact firing edge can be checked. In the random phase, the ceiling is reprogrammed to values between 3 and 40, so up and down wraps, index resets and gating mismatches all occur many times within a few thousand cycles.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef struct packed {
    logic step;
    logic up;
    logic illegal;
    logic idxHit;
    logic wdtFire;
  } qpcStrobe_t;

  localparam int STAT_WDT = 0;
  localparam int STAT_DN  = 1;
  localparam int STAT_UP  = 2;
  localparam int STAT_DIR = 3;

  localparam int CTL_EN    = 0;
  localparam int CTL_EA    = 2;
  localparam int CTL_EB    = 3;
  localparam int CTL_EI    = 4;
  localparam int CTL_SWAP  = 5;
  localparam int CTL_PERR  = 7;
  localparam int CTL_RMODE = 8;
  localparam int CTL_GLO   = 9;

  localparam logic [2:0] ADR_CTL  = 3'd0;
  localparam logic [2:0] ADR_CEIL = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_WDT  = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;
  localparam logic [2:0] ADR_MASK = 3'd5;
endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int WDT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pinA,
  input  logic             pinB,
  input  logic             pinIdx,
  input  logic             en,
  input  logic             swap,
  input  logic             idxRise,
  input  logic [1:0]       idxGate,
  input  logic             idxResetEn,
  input  logic [WDT_W-1:0] wdtLimit,
  output qpcStrobe_t       strobe
);
  logic phA, phB;
  logic prevA, prevB, prevGate;
  logic chgA, chgB;
  logic gated, idxEdge;
  logic [WDT_W-1:0] idleCnt;

  assign phA = swap ? pinB : pinA;
  assign phB = swap ? pinA : pinB;
  assign chgA = phA ^ prevA;
  assign chgB = phB ^ prevB;

  // gating uses the pins as wired, independent of the swap
  assign gated   = pinIdx && (pinA == idxGate[1]) && (pinB == idxGate[0]);
  assign idxEdge = idxRise ? (gated && !prevGate) : (!gated && prevGate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      prevGate <= 1'b0;
    end else begin
      prevA    <= phA;
      prevB    <= phB;
      prevGate <= gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (!en || chgA || chgB) begin
      idleCnt <= '0;
    end else if (idleCnt < wdtLimit) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.step    = en && (chgA ^ chgB);
    strobe.up      = !(prevA ^ phB);
    strobe.illegal = en && chgA && chgB;
    strobe.idxHit  = en && idxResetEn && idxEdge;
    strobe.wdtFire = en && !(chgA || chgB) && (wdtLimit != '0)
                     && (idleCnt == wdtLimit - 1'b1);
  end

  // R8: one idle period raises the watchdog strobe only once
  p_wdt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wdtFire && $stable(wdtLimit)) |=> !strobe.wdtFire);

  // R3: nothing is strobed while counting is off
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(strobe.step || strobe.illegal || strobe.idxHit || strobe.wdtFire));
endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int               COUNT_W   = 32,
  parameter int               WDT_W     = 16,
  parameter int               DATA_W    = 32,
  parameter logic [WDT_W-1:0] WDT_RESET = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  input  qpcStrobe_t        strobe,
  output logic              en,
  output logic              swap,
  output logic              idxRise,
  output logic [1:0]        idxGate,
  output logic              idxResetEn,
  output logic [WDT_W-1:0]  wdtLimit
);
  localparam int STAT_W = 6;
  localparam int EVT_W  = 4;

  logic               edgeA, edgeB, phErr, rstMode;
  logic [COUNT_W-1:0] ceiling, count;
  logic [EVT_W-1:0]   status, evt, statClr;
  logic [STAT_W-1:0]  mask;
  logic               lastUp;
  logic               wrCtl, wrStat;
  logic               wrapUp, wrapDn;

  assign wrCtl      = regWe && (regAddr == ADR_CTL);
  assign wrStat     = regWe && (regAddr == ADR_STAT);
  assign idxResetEn = !rstMode;

  // control and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      edgeA    <= 1'b1;
      edgeB    <= 1'b1;
      idxRise  <= 1'b1;
      swap     <= 1'b0;
      rstMode  <= 1'b1;
      idxGate  <= 2'd0;
      ceiling  <= '1;
      wdtLimit <= WDT_RESET;
      mask     <= '0;
    end else if (regWe) begin
      unique case (regAddr)
        ADR_CTL: begin
          en      <= regWrData[CTL_EN];
          edgeA   <= regWrData[CTL_EA];
          edgeB   <= regWrData[CTL_EB];
          idxRise <= regWrData[CTL_EI];
          swap    <= regWrData[CTL_SWAP];
          rstMode <= regWrData[CTL_RMODE];
          idxGate <= regWrData[CTL_GLO+1:CTL_GLO];
        end
        ADR_CEIL: ceiling  <= regWrData[COUNT_W-1:0];
        ADR_WDT:  wdtLimit <= regWrData[WDT_W-1:0];
        ADR_MASK: mask     <= regWrData[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  // position counter
  assign wrapUp = strobe.step && strobe.up && !strobe.idxHit && (count >= ceiling);
  assign wrapDn = strobe.step && !strobe.up && !strobe.idxHit && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobe.idxHit) begin
      count <= '0;
    end else if (strobe.step) begin
      if (strobe.up) count <= wrapUp ? '0 : count + 1'b1;
      else           count <= wrapDn ? ceiling : count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lastUp <= 1'b1;
    else if (strobe.step) lastUp <= strobe.up;
  end

  // events and sticky flags
  always_comb begin
    evt           = '0;
    evt[STAT_WDT] = strobe.wdtFire;
    evt[STAT_DN]  = wrapDn;
    evt[STAT_UP]  = wrapUp;
    evt[STAT_DIR] = strobe.step && (strobe.up != lastUp);
    statClr       = wrStat ? regWrData[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~statClr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            phErr <= 1'b0;
    else if (strobe.illegal)               phErr <= 1'b1;
    else if (wrCtl && regWrData[CTL_PERR]) phErr <= 1'b0;
  end

  assign irq = |(status & ~mask[EVT_W-1:0]);

  // read mux
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADR_CTL: begin
        regRdData[CTL_EN]                  = en;
        regRdData[CTL_EA]                  = edgeA;
        regRdData[CTL_EB]                  = edgeB;
        regRdData[CTL_EI]                  = idxRise;
        regRdData[CTL_SWAP]                = swap;
        regRdData[CTL_PERR]                = phErr;
        regRdData[CTL_RMODE]               = rstMode;
        regRdData[CTL_GLO+1:CTL_GLO]       = idxGate;
      end
      ADR_CEIL: regRdData = DATA_W'(ceiling);
      ADR_CNT:  regRdData = DATA_W'(count);
      ADR_WDT:  regRdData = DATA_W'(wdtLimit);
      ADR_STAT: regRdData = DATA_W'(status);
      ADR_MASK: regRdData = DATA_W'(mask);
      default:  regRdData = '0;
    endcase
  end

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && strobe.up && !strobe.idxHit && count >= ceiling)
      |=> (count == '0 && status[STAT_UP]));

  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !strobe.up && !strobe.idxHit && count == '0)
      |=> (count == $past(ceiling) && status[STAT_DN]));

  p_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.idxHit |=> count == '0);

  p_dir_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && strobe.up != lastUp) |=> status[STAT_DIR]);

  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.illegal && !strobe.idxHit) |=> ($stable(count) && phErr));
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int WDT_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        encA,
  input  logic        encB,
  input  logic        encIdx,
  input  logic [2:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq
);
  qpcStrobe_t       strobe;
  logic             en, swap, idxRise, idxResetEn;
  logic [1:0]       idxGate;
  logic [WDT_W-1:0] wdtLimit;

  qpc_ctrl #(.WDT_W(WDT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pinA(encA), .pinB(encB), .pinIdx(encIdx),
    .en(en), .swap(swap), .idxRise(idxRise), .idxGate(idxGate),
    .idxResetEn(idxResetEn), .wdtLimit(wdtLimit),
    .strobe(strobe)
  );

  qpc_datapath #(.COUNT_W(COUNT_W), .WDT_W(WDT_W), .DATA_W(32)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .regAddr(regAddr), .regWe(regWe), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq),
    .strobe(strobe),
    .en(en), .swap(swap), .idxRise(idxRise), .idxGate(idxGate),
    .idxResetEn(idxResetEn), .wdtLimit(wdtLimit)
  );
endmodule

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
  localparam int CW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pA = 0, pB = 0, pI = 0;
  logic [2:0] regAddr = '0;
  logic regWe = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq;

  quad_pos_counter #(.COUNT_W(CW)) u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .encA(pA), .encB(pB), .encIdx(pI),
    .regAddr(regAddr), .regWe(regWe), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq));

  always #5 clk = ~clk;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  // bench mirror of configuration and expected state
  logic mEn = 0, mSwap = 0, mRise = 1, mRmode = 1;
  logic [1:0] mGate = 0;
  logic [CW-1:0] mCeil = '1, mCnt = '0;
  logic [3:0] mStat = '0;
  logic mLastUp = 1, mPrevA = 0, mPrevB = 0, mPrevG = 0, mPhErr = 0;

  function automatic int posOf(logic a, logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] pairOf(int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  // expected effect of the cycle about to be sampled
  task automatic modelStep();
    logic sa, sb, g, ie, hit, up;
    int d;
    sa = mSwap ? pB : pA;
    sb = mSwap ? pA : pB;
    d = (posOf(sa, sb) - posOf(mPrevA, mPrevB)) & 3;
    g = pI && (pA == mGate[1]) && (pB == mGate[0]);
    ie = mRise ? (g && !mPrevG) : (!g && mPrevG);
    hit = mEn && !mRmode && ie;
    if (mEn) begin
      if (d == 2) mPhErr = 1;
      if (d == 1 || d == 3) begin
        up = (d == 1);
        if (up != mLastUp) mStat[3] = 1;
        mLastUp = up;
        if (!hit) begin
          if (up) begin
            if (mCnt >= mCeil) begin mCnt = '0; mStat[2] = 1; end
            else mCnt = mCnt + 1'b1;
          end else begin
            if (mCnt == '0) begin mCnt = mCeil; mStat[1] = 1; end
            else mCnt = mCnt - 1'b1;
          end
        end
      end
      if (hit) mCnt = '0;
    end
    mPrevA = sa; mPrevB = sb; mPrevG = g;
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
  endtask

  task automatic setPins(logic a, logic b, logic i);
    pA = a; pB = b; pI = i;
    tick();
  endtask

  task automatic move(bit up, int n);
    for (int k = 0; k < n; k++) begin
      logic [1:0] pr;
      pr = pairOf(posOf(pA, pB) + (up ? 1 : 3));
      setPins(pr[1], pr[0], pI);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    if (a == 3'd4) mStat = mStat & ~d[3:0];
    if (a == 3'd0 && d[7]) mPhErr = 0;
    regAddr = a; regWrData = d; regWe = 1;
    tick();
    regWe = 0;
    if (a == 3'd0) begin
      mEn = d[0]; mRise = d[4]; mSwap = d[5]; mRmode = d[8]; mGate = d[10:9];
    end
    if (a == 3'd1) mCeil = d[CW-1:0];
  endtask

  task automatic chkModel(string tag);
    logic [31:0] v;
    rd(3'd2, v); check({tag, " count"}, v, 32'(mCnt));
    rd(3'd4, v); check({tag, " status"}, {28'd0, v[3:1], 1'b0}, {28'd0, mStat[3:1], 1'b0});
    rd(3'd0, v); check({tag, " phase error"}, 32'(v[7]), 32'(mPhErr));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset values, R8 timeout reset
    rd(3'd0, v); check("R11 control reset", v, 32'h11C);
    rd(3'd1, v); check("R11 ceiling reset", v, 32'hFFF);
    rd(3'd2, v); check("R11 count reset", v, 0);
    rd(3'd4, v); check("R11 status reset", v, 0);
    rd(3'd5, v); check("R11 mask reset", v, 0);
    rd(3'd3, v); check("R8 timeout reset", v, 32'h1000);
    check("R9 irq reset", 32'(irq), 0);

    // R3 disabled: nothing counts
    move(1, 4);
    rd(3'd2, v); check("R3 count held", v, 0);
    rd(3'd4, v); check("R3 no events", v, 0);

    // R1 forward and backward
    wr(3'd0, 32'h11D);
    move(1, 5);
    rd(3'd2, v); check("R1 up count", v, 5);
    rd(3'd4, v); check("R7 no event on initial forward", 32'(v[3]), 0);
    move(0, 2);
    rd(3'd2, v); check("R1 down count", v, 3);
    rd(3'd4, v); check("R7 direction event", 32'(v[3]), 1);
    check("R9 irq on event", 32'(irq), 1);
    wr(3'd4, 32'h3F);
    rd(3'd4, v); check("R9 write-one clear", v, 0);
    check("R9 irq after clear", 32'(irq), 0);

    // R5 down wrap to ceiling
    move(0, 4);
    rd(3'd2, v); check("R5 down wrap count", v, 32'hFFF);
    rd(3'd4, v); check("R5 down wrap event", 32'(v[1]), 1);

    // R4 up wrap after lowering the ceiling
    wr(3'd1, 3);
    move(1, 1);
    rd(3'd2, v); check("R4 wrap above ceiling", v, 0);
    rd(3'd4, v); check("R4 up wrap event", 32'(v[2]), 1);
    move(1, 4);
    rd(3'd2, v); check("R4 wrap at ceiling", v, 0);

    // R9 mask
    wr(3'd5, 32'h3F);
    check("R9 masked irq", 32'(irq), 0);
    rd(3'd4, v); check("R9 status kept while masked", 32'(v[2]), 1);
    check("R9 fifo bits zero", 32'(v[5:4]), 0);
    wr(3'd5, 0);
    check("R9 unmasked irq", 32'(irq), 1);
    wr(3'd4, 32'hF);
    wr(3'd1, 100);

    // R10 illegal transition
    move(1, 2);
    rd(3'd2, v); keep = v;
    setPins(~pA, ~pB, pI);
    rd(3'd2, v); check("R10 illegal holds count", v, keep);
    rd(3'd0, v); check("R10 sticky flag", 32'(v[7]), 1);
    wr(3'd0, 32'h19D);
    rd(3'd0, v); check("R10 flag cleared", 32'(v[7]), 0);
    chkModel("R10 model");

    // R2 swapped decoding
    wr(3'd0, 32'h11C);
    wr(3'd0, 32'h13C);
    wr(3'd0, 32'h13D);
    rd(3'd2, v); keep = v;
    move(1, 2);
    rd(3'd2, v); check("R2 swap reverses", v, keep - 2);
    wr(3'd0, 32'h11C);
    wr(3'd0, 32'h11D);

    // R6 index gating and reset mode
    wr(3'd0, 32'h61D);
    while (posOf(pA, pB) != 2) move(1, 1);
    move(1, 1); move(0, 1);
    setPins(pA, pB, 1);
    rd(3'd2, v); check("R6 gated index zeroes", v, 0);
    setPins(pA, pB, 0);
    move(0, 1);
    rd(3'd2, v); keep = v;
    setPins(pA, pB, 1);
    setPins(pA, pB, 0);
    rd(3'd2, v); check("R6 gate mismatch ignored", v, keep);
    wr(3'd0, 32'h71D);
    move(1, 1);
    rd(3'd2, v); keep = v;
    setPins(pA, pB, 1);
    setPins(pA, pB, 0);
    rd(3'd2, v); check("R6 ceiling mode ignores index", v, keep);
    chkModel("R6 model");

    // R8 watchdog timing
    wr(3'd3, 20);
    wr(3'd4, 32'hF);
    move(1, 1);
    repeat (19) tick();
    rd(3'd4, v); check("R8 not yet", 32'(v[0]), 0);
    tick();
    rd(3'd4, v); check("R8 fires at timeout", 32'(v[0]), 1);
    wr(3'd3, 32'h1000);

    // constrained random against the model
    for (int c = 0; c < 3000; c++) begin
      int r;
      if (c % 250 == 0) begin
        logic [31:0] cfg;
        cfg = 32'h1C | (32'($urandom % 2) << 8) | (32'($urandom % 4) << 9)
              | (32'($urandom % 2) << 4) | (32'($urandom % 2) << 5);
        wr(3'd0, cfg);
        wr(3'd1, 3 + $urandom % 38);
        wr(3'd0, cfg | 32'h81);
      end
      r = $urandom % 16;
      if (r < 6) move(1, 1);
      else if (r < 11) move(0, 1);
      else if (r == 11) tick();
      else if (r == 12) setPins(~pA, ~pB, pI);
      else if (r == 13) wr(3'd4, $urandom % 16);
      else setPins(pA, pB, ~pI);
      chkModel("R1 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule